// File: doc/BRIEF.md
# Masked Open-Drain Pad Pair Register

This block is a single control and status register for a pair of pads, a clock pad and a data pad, that software toggles bit by bit to run an I2C link. For each pad the register holds a direction bit and an output-value bit. Each of these has its own write-enable bit inside the written word, so one write can touch one field of one pad and leave every other field exactly as it was. Software never has to read the register before it writes.

The outputs behave as open drain only because of how software uses the direction bit. To release a line it switches the pad to input and leaves the stored value alone. To pull the line low it switches the pad to output with a stored value of 0. The level on each pad comes back through a two-flop synchronizer and appears as a read-only bit. Each pad also has a pull-up disable bit. Pin-toggling writes leave it alone; only a write that carries no write-enable bit at all changes it.

Top module: `gpio_pair_reg`

## Requirements
- R1: After reset both pads are inputs (`pad_oe` = 0), both stored values are 0, both pull-up disable bits are 0, and `rd_data` reads all zero while `pad_in` is 0.
- R2: Pad k uses bits [8k+7:8k] of the register (pad 0 = clock, pad 1 = data). Within that byte, bit 1 is the direction (1 = output) and bit 0 is its write-enable. A write changes the direction only when bit 0 is 1 in that same write.
- R3: Within a pad byte, bit 3 is the output value and bit 2 is its write-enable. A write changes the value only when bit 2 is 1 in that same write.
- R4: A write with direction 0, the direction enable set and the value enable clear releases the pad (`pad_oe` falls after one clock edge) and keeps the stored value.
- R5: A write with direction 1, value 0 and both enables set (byte value 0x07) drives the pad low: after one clock edge `pad_oe` = 1 and `pad_out` = 0.
- R6: `pad_oe[k]` is 1 exactly while pad k's direction is output. `pad_out[k]` always shows the stored value, including while the pad is an input.
- R7: Bit 4 of a pad byte is read-only and reports `pad_in[k]` two clock edges after it changes, never after only one. A write does not disturb it.
- R8: Bit 5 of a pad byte is the pull-up disable, visible on `pad_pu_dis[k]`. It is loaded only by a write in which all direction and value enable bits of both pads are 0. Such a write changes no direction or value, and any write with an enable bit set leaves both pull-up bits unchanged.
- R9: On `rd_data` the enable bits (0 and 2) and the unused bits (6 and 7) of each byte read 0. Bits 1, 3, 4 and 5 read the stored state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, asynchronous assert |
| wr_en | input | 1 | Write strobe for the register |
| wr_data | input | 16 | Written word: one byte per pad |
| rd_data | output | 16 | Register read value |
| pad_in | input | 2 | Raw pad levels, bit 0 clock, bit 1 data |
| pad_oe | output | 2 | Pad output enable, 1 while the pad drives |
| pad_out | output | 2 | Level driven when enabled |
| pad_pu_dis | output | 2 | Pull-up disable per pad |

## Verification
A register write and a change of pad level can land in the same clock edge. The write then updates the direction while the synchronizer is still moving the new level through its stages. The bench makes this happen by changing `pad_in` and issuing a write on the same falling edge. It then checks that the output enable follows the write after one edge, while the input bit on `rd_data` still reads the old level after one edge and the new level after two. A second coincidence has a direction update and a value update in one write (the drive-low word). The bench checks it through `pad_oe` and `pad_out` together after a single edge.

// File: rtl/gpio_pair_pkg.sv
package gpio_pair_pkg;

  // one byte per pad in the register word
  localparam int LANE_W    = 8;
  localparam int B_DIR_EN  = 0;
  localparam int B_DIR     = 1;
  localparam int B_VAL_EN  = 2;
  localparam int B_VAL     = 3;
  localparam int B_IN      = 4;
  localparam int B_PUD     = 5;

  // new value when the enable is set, otherwise keep the stored bit
  function automatic logic masked_pick(input logic keep, input logic nv, input logic en);
    return en ? nv : keep;
  endfunction

  // compose a read byte: enables and unused bits read zero
  function automatic logic [LANE_W-1:0] pack_lane(input logic dir, input logic val,
                                                  input logic lvl, input logic pud);
    logic [LANE_W-1:0] b;
    b          = '0;
    b[B_DIR]   = dir;
    b[B_VAL]   = val;
    b[B_IN]    = lvl;
    b[B_PUD]   = pud;
    return b;
  endfunction

endpackage

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] st;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st <= '0;
    else        st <= {st[STAGES-2:0], d};
  end

  assign q = st[STAGES-1];

  // cycles since reset, saturating, for the latency check
  logic [1:0] since_rst;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               since_rst <= '0;
    else if (since_rst != 2'd3) since_rst <= since_rst + 2'd1;
  end

  generate
    if (STAGES == 2) begin : g_chk2
      // R7: a change at the output repeats the input seen two edges earlier
      p_sync_lat_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst == 2'd3 && q != $past(q)) |-> (q == $past(d, 2)));
    end
  endgenerate

endmodule

// File: rtl/gpio_reg_decode.sv
module gpio_reg_decode
  import gpio_pair_pkg::*;
#(
  parameter int NPADS = 2,
  localparam int REG_W = NPADS * LANE_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_data,
  output logic [NPADS-1:0] dir_we,
  output logic [NPADS-1:0] dir_wd,
  output logic [NPADS-1:0] val_we,
  output logic [NPADS-1:0] val_wd,
  output logic             pud_we,
  output logic [NPADS-1:0] pud_wd
);
  logic [NPADS-1:0] any_en_lane;
  logic [NPADS-1:0] unused_bits;

  genvar k;
  generate
    for (k = 0; k < NPADS; k++) begin : g_lane
      localparam int BASE = k * LANE_W;
      assign dir_we[k]      = wr_en & wr_data[BASE + B_DIR_EN];
      assign dir_wd[k]      = wr_data[BASE + B_DIR];
      assign val_we[k]      = wr_en & wr_data[BASE + B_VAL_EN];
      assign val_wd[k]      = wr_data[BASE + B_VAL];
      assign pud_wd[k]      = wr_data[BASE + B_PUD];
      assign any_en_lane[k] = wr_data[BASE + B_DIR_EN] | wr_data[BASE + B_VAL_EN];
      assign unused_bits[k] = ^{wr_data[BASE + B_IN], wr_data[BASE + LANE_W - 1 : BASE + B_PUD + 1]};
    end
  endgenerate

  // configuration write: no enable bit anywhere in the word
  assign pud_we = wr_en & ~(|any_en_lane);

  // R8: a configuration write never coincides with a pin update
  p_cfg_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
    pud_we |-> (dir_we == '0 && val_we == '0));

endmodule

// File: rtl/gpio_pad_lane.sv
module gpio_pad_lane
  import gpio_pair_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic dir_we,
  input  logic dir_wd,
  input  logic val_we,
  input  logic val_wd,
  input  logic pud_we,
  input  logic pud_wd,
  output logic dir_q,
  output logic val_q,
  output logic pud_q
);
  logic dir_nx, val_nx, pud_nx;

  always_comb begin
    dir_nx = masked_pick(dir_q, dir_wd, dir_we);
    val_nx = masked_pick(val_q, val_wd, val_we);
    pud_nx = masked_pick(pud_q, pud_wd, pud_we);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q <= 1'b0;
      val_q <= 1'b0;
      pud_q <= 1'b0;
    end else begin
      dir_q <= dir_nx;
      val_q <= val_nx;
      pud_q <= pud_nx;
    end
  end

  // R2: direction holds without its enable
  p_dir_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !dir_we |=> $stable(dir_q));
  // R3: value holds without its enable
  p_val_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !val_we |=> $stable(val_q));
  // R4: release leaves the pad an input with its value kept
  p_release_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (dir_we && !dir_wd && !val_we) |=> (!dir_q && $stable(val_q)));
  // R5: drive-low word leaves the pad driving 0
  p_drive_low_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (dir_we && dir_wd && val_we && !val_wd) |=> (dir_q && !val_q));
  // R8: pull-up bit holds on pin writes
  p_pud_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (dir_we || val_we) |=> $stable(pud_q));

endmodule

// File: rtl/gpio_pair_reg.sv
module gpio_pair_reg
  import gpio_pair_pkg::*;
#(
  parameter int NPADS       = 2,
  parameter int SYNC_STAGES = 2,
  localparam int REG_W      = NPADS * LANE_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_data,
  output logic [REG_W-1:0] rd_data,
  input  logic [NPADS-1:0] pad_in,
  output logic [NPADS-1:0] pad_oe,
  output logic [NPADS-1:0] pad_out,
  output logic [NPADS-1:0] pad_pu_dis
);
  logic [NPADS-1:0] dir_we, dir_wd, val_we, val_wd, pud_wd;
  logic             pud_we;
  logic [NPADS-1:0] dir_q, val_q, pud_q, lvl_q;

  gpio_reg_decode #(.NPADS(NPADS)) u_dec (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_data (wr_data),
    .dir_we  (dir_we),
    .dir_wd  (dir_wd),
    .val_we  (val_we),
    .val_wd  (val_wd),
    .pud_we  (pud_we),
    .pud_wd  (pud_wd)
  );

  genvar k;
  generate
    for (k = 0; k < NPADS; k++) begin : g_pad
      gpio_pad_lane u_lane (
        .clk    (clk),
        .rst_n  (rst_n),
        .dir_we (dir_we[k]),
        .dir_wd (dir_wd[k]),
        .val_we (val_we[k]),
        .val_wd (val_wd[k]),
        .pud_we (pud_we),
        .pud_wd (pud_wd[k]),
        .dir_q  (dir_q[k]),
        .val_q  (val_q[k]),
        .pud_q  (pud_q[k])
      );

      gpio_in_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (pad_in[k]),
        .q     (lvl_q[k])
      );

      assign rd_data[k*LANE_W +: LANE_W] = pack_lane(dir_q[k], val_q[k], lvl_q[k], pud_q[k]);
    end
  endgenerate

  assign pad_oe     = dir_q;
  assign pad_out    = val_q;
  assign pad_pu_dis = pud_q;

  // R6: an output enable only switches on after a write
  p_oe_rise_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (|(pad_oe & ~$past(pad_oe))) |-> $past(wr_en));
  // R9: enable and spare bits of every byte read zero
  always_comb begin
    for (int i = 0; i < NPADS; i++) begin
      a_rd_zero_r9: assert (rd_data[i*LANE_W + B_DIR_EN] == 1'b0 &&
                            rd_data[i*LANE_W + B_VAL_EN] == 1'b0 &&
                            rd_data[i*LANE_W + LANE_W - 1 -: 2] == 2'b00);
    end
  end

endmodule

// File: tb/sim_gpio_pair_reg.sv
`timescale 1ns/1ps
module sim_gpio_pair_reg;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [15:0] wr_data = '0;
  logic [15:0] rd_data;
  logic [1:0]  pad_in = '0;
  logic [1:0]  pad_oe, pad_out, pad_pu_dis;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  gpio_pair_reg u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
    .pad_in(pad_in), .pad_oe(pad_oe), .pad_out(pad_out), .pad_pu_dis(pad_pu_dis)
  );

  // expected read word from the requirement layout (R9)
  function automatic logic [15:0] exp_rd(input logic [1:0] oe, input logic [1:0] val,
                                         input logic [1:0] lvl, input logic [1:0] pud);
    logic [15:0] w = '0;
    for (int p = 0; p < 2; p++) begin
      w[p*8 + 1] = oe[p];
      w[p*8 + 3] = val[p];
      w[p*8 + 4] = lvl[p];
      w[p*8 + 5] = pud[p];
    end
    return w;
  endfunction

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [15:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0; wr_data = '0;
  endtask

  // {word, oe, out, pud}
  typedef struct packed { logic [15:0] w; logic [1:0] oe; logic [1:0] vo; logic [1:0] pu; } vec_t;
  localparam vec_t VECS [10] = '{
    '{16'h0003, 2'b01, 2'b00, 2'b00},  // R2 clock pad to output
    '{16'h000C, 2'b01, 2'b01, 2'b00},  // R3 clock value 1
    '{16'h0A0A, 2'b01, 2'b01, 2'b00},  // R2 R3 fields without enables ignored
    '{16'h0F00, 2'b11, 2'b11, 2'b00},  // data pad driven high
    '{16'h0001, 2'b10, 2'b11, 2'b00},  // R4 release clock, value kept
    '{16'h0700, 2'b10, 2'b01, 2'b00},  // R5 drive data low
    '{16'h2020, 2'b10, 2'b01, 2'b11},  // R8 configuration write
    '{16'h000D, 2'b10, 2'b01, 2'b11},  // R8 pin write keeps pull-ups
    '{16'h0020, 2'b10, 2'b01, 2'b01},  // R8 configuration write clears one
    '{16'h0307, 2'b11, 2'b00, 2'b01}   // R5 R6 both pads driving low
  };

  initial begin
    #(200000 * 5);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 oe", {14'd0, pad_oe}, 16'h0000);
    chk("R1 out", {14'd0, pad_out}, 16'h0000);
    chk("R1 pud", {14'd0, pad_pu_dis}, 16'h0000);
    chk("R1 rd", rd_data, 16'h0000);

    for (int i = 0; i < 10; i++) begin
      wr(VECS[i].w);
      chk($sformatf("R2 R3 R6 vec%0d oe", i), {14'd0, pad_oe}, {14'd0, VECS[i].oe});
      chk($sformatf("R3 R6 vec%0d out", i), {14'd0, pad_out}, {14'd0, VECS[i].vo});
      chk($sformatf("R8 vec%0d pud", i), {14'd0, pad_pu_dis}, {14'd0, VECS[i].pu});
      chk($sformatf("R9 vec%0d rd", i), rd_data, exp_rd(VECS[i].oe, VECS[i].vo, 2'b00, VECS[i].pu));
    end

    // R7 with a write in the same cycle: state now oe=11 out=00 pud=01
    @(negedge clk);
    pad_in = 2'b11; wr_en = 1'b1; wr_data = 16'h0001;  // release clock pad
    @(negedge clk);
    wr_en = 1'b0; wr_data = '0;
    chk("R4 oe same cycle", {14'd0, pad_oe}, 16'h0002);
    chk("R7 one edge old level", rd_data, exp_rd(2'b10, 2'b00, 2'b00, 2'b01));
    @(negedge clk);
    chk("R7 two edges new level", rd_data, exp_rd(2'b10, 2'b00, 2'b11, 2'b01));
    pad_in = 2'b10;
    @(negedge clk);
    chk("R7 fall one edge", rd_data, exp_rd(2'b10, 2'b00, 2'b11, 2'b01));
    @(negedge clk);
    chk("R7 fall two edges", rd_data, exp_rd(2'b10, 2'b00, 2'b10, 2'b01));

    // R6 value visible while input
    wr(16'h000C);
    chk("R6 out while input", {14'd0, pad_out, pad_oe}, 16'h0006);

    // R1 reset after activity
    rst_n = 1'b0;
    @(negedge clk);
    pad_in = 2'b00;
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk("R1 rd after reset", rd_data, 16'h0000);
    chk("R1 pins after reset", {10'd0, pad_oe, pad_out, pad_pu_dis}, 16'h0000);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule